// File: doc/BRIEF.md
# PCI Target Command Decoder and Burst Address Sequencer

This block sits at the front of a PCI target. In the cycle marked as the address phase it captures the 4-bit bus command and the 32-bit address. It decides whether the target claims the transaction and folds the several memory read and write command aliases onto a basic read or write. Configuration accesses are reported as their own kinds. Reserved, I/O, special and dual-address commands are left alone.

Once a transaction is claimed, the block keeps a byte address for the current data beat and moves it on each time a beat-advance strobe arrives. The step is linear (+4) or wraps inside a cache line. Wrap applies only when the command permits it and the address mode bits ask for it. The line size comes from a small programmable register that holds 4, 8 or 16 words. Its value is sampled at the address phase, so every burst keeps one line size from start to finish.

All outputs are registered. They change one clock edge after the address phase or the beat strobe that caused them. The bus handshakes, parity, arbitration and the initiator side belong to other blocks.

Top module: `pci_tgt_front`

## Requirements
- R1: After a synchronous reset, `claim`, `wrap_en` and `kind` are 0 and `beat_addr` is 0. The line size register holds 8 words (code 1).
- R2: When `addr_valid` is high, the command is decoded and the result appears one edge later. `kind` encodes 00 = memory read, 01 = memory write, 10 = configuration read, 11 = configuration write. Commands 0110, 1100 and 1110 claim as memory read. Commands 0111 and 1111 claim as memory write. Commands 1010 and 1011 claim as configuration read and configuration write.
- R3: Commands 1000, 1001, 1101 and 0000 to 0101 are not claimed. For these, `claim`, `kind` and `wrap_en` read 0 and `beat_addr` reads 0. While no transaction is claimed, `beat_adv` leaves `beat_addr` unchanged.
- R4: A memory command whose address bits [1:0] are 01 or 11 (reserved orders) is not claimed.
- R5: `wrap_en` is 1 only for commands 1100 and 1111 with address bits [1:0] = 10. Commands 0110, 0111 and 1110 with bits [1:0] = 10 are claimed and run linear.
- R6: In a linear memory burst, `beat_addr` starts at the address with bits [1:0] cleared. Each `beat_adv` adds 4, modulo 2^32.
- R7: In a wrap burst, each `beat_adv` steps the word index (byte address bits above [1:0]) by one, modulo the line size. Bits above the line stay fixed.
- R8: A configuration access is claimed whatever address bits [1:0] hold. `beat_addr` is {24 zero bits, address[7:2], 00}, and each beat adds 4 modulo 256.
- R9: Pulsing `line_wr` with `line_code` 0, 1 or 2 sets the line size to 4, 8 or 16 words. Code 3 is ignored. A burst uses the size held at its address phase.
- R10: A new address phase reloads the sequencer and drops any burst in progress. When `addr_valid` and `beat_adv` are both high in one cycle, the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address phase marker; captures cmd and ad |
| cmd | input | 4 | Bus command nibble |
| ad | input | 32 | Address captured at the address phase |
| beat_adv | input | 1 | Advance to the next data beat |
| line_wr | input | 1 | Write strobe for the line size register |
| line_code | input | 2 | Line size code: 0=4, 1=8, 2=16 words, 3 ignored |
| claim | output | 1 | Transaction is claimed by this target |
| kind | output | 2 | Transaction kind (see R2) |
| wrap_en | output | 1 | Burst wraps inside a cache line |
| beat_addr | output | 32 | Byte address of the current data beat |

## Verification
The assertions run on every cycle. They check that an unclaimed transaction never shows a wrap flag or a kind, and that dual-address commands and reserved memory orders are never claimed. They also check that linear beats step by exactly four and that wrap beats never disturb the bits above the line. Further checks cover the zero upper byte of a configuration address, a frozen address while nothing is claimed, and that an invalid size code leaves the line register alone. Only the bench scenarios can show that each command maps onto the right kind. The same holds for the wrap point landing at the correct line boundary for each size, the size staying fixed across a mid-burst register write, and a reload taking priority over a simultaneous beat strobe.

// File: rtl/pci_tf_pkg.sv
package pci_tf_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    KIND_MEM_RD = 2'b00,
    KIND_MEM_WR = 2'b01,
    KIND_CFG_RD = 2'b10,
    KIND_CFG_WR = 2'b11
  } xact_kind_e;

  typedef struct packed {
    logic       claim;
    xact_kind_e kind;
    logic       wrap;
    logic       is_cfg;
  } decode_t;

  localparam logic [1:0] ORDER_LINEAR = 2'b00;
  localparam logic [1:0] ORDER_WRAP   = 2'b10;

endpackage

// File: rtl/pci_tf_cmd_decode.sv
module pci_tf_cmd_decode
  import pci_tf_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic [1:0]       order,
  output decode_t          dec
);

  logic is_mem;
  logic wrap_ok;

  always_comb begin
    dec     = '0;
    is_mem  = 1'b0;
    wrap_ok = 1'b0;
    case (cmd)
      4'b0110: begin is_mem = 1'b1; dec.kind = KIND_MEM_RD; end
      4'b0111: begin is_mem = 1'b1; dec.kind = KIND_MEM_WR; end
      4'b1100: begin is_mem = 1'b1; dec.kind = KIND_MEM_RD; wrap_ok = 1'b1; end
      4'b1110: begin is_mem = 1'b1; dec.kind = KIND_MEM_RD; end
      4'b1111: begin is_mem = 1'b1; dec.kind = KIND_MEM_WR; wrap_ok = 1'b1; end
      4'b1010: begin dec.claim = 1'b1; dec.is_cfg = 1'b1; dec.kind = KIND_CFG_RD; end
      4'b1011: begin dec.claim = 1'b1; dec.is_cfg = 1'b1; dec.kind = KIND_CFG_WR; end
      default: ;
    endcase
    if (is_mem) begin
      if (order == ORDER_LINEAR || order == ORDER_WRAP) begin
        dec.claim = 1'b1;
        dec.wrap  = wrap_ok && (order == ORDER_WRAP);
      end else begin
        dec.kind = KIND_MEM_RD;
      end
    end
  end

  // R3 / R4: an unclaimed decode never carries a kind or wrap
  always_comb begin
    if (!dec.claim)
      assert_unclaimed_clean_R3: assert (dec.kind == KIND_MEM_RD && !dec.wrap && !dec.is_cfg);
  end

endmodule

// File: rtl/pci_tf_line_size.sv
module pci_tf_line_size #(
  parameter int MAX_LINE_LOG2   = 4,
  parameter int MIN_LINE_LOG2   = 2,
  parameter int RESET_LINE_LOG2 = 3,
  parameter int CODE_W          = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [CODE_W-1:0]        code,
  output logic [MAX_LINE_LOG2-1:0] word_mask
);

  localparam int LOG_W = $clog2(MAX_LINE_LOG2 + 1);

  logic [LOG_W-1:0] log2_q;
  logic             code_ok;

  assign code_ok = (int'(code) <= (MAX_LINE_LOG2 - MIN_LINE_LOG2));

  always_ff @(posedge clk) begin
    if (rst)
      log2_q <= LOG_W'(RESET_LINE_LOG2);
    else if (wr_en && code_ok)
      log2_q <= LOG_W'(int'(code) + MIN_LINE_LOG2);
  end

  always_comb begin
    for (int i = 0; i < MAX_LINE_LOG2; i++)
      word_mask[i] = (i < int'(log2_q));
  end

  // R9: an out-of-range code leaves the size untouched
  assert_bad_code_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !code_ok) |=> $stable(log2_q));

  // R9: size stays inside the supported range
  assert_size_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(log2_q) >= MIN_LINE_LOG2) && (int'(log2_q) <= MAX_LINE_LOG2));

endmodule

// File: rtl/pci_tf_beat_seq.sv
module pci_tf_beat_seq
  import pci_tf_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CFG_BITS      = 8,
  parameter int MAX_LINE_LOG2 = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  decode_t                  dec,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic [MAX_LINE_LOG2-1:0] word_mask,
  input  logic                     adv,
  output logic [ADDR_W-1:0]        cur_addr
);

  localparam int WI_HI = MAX_LINE_LOG2 + 1;

  logic [ADDR_W-1:0]        cur_q, nxt_lin, nxt_wrap, nxt_cfg;
  logic [MAX_LINE_LOG2-1:0] mask_q, widx, widx_inc;
  logic                     active_q, wrap_q, cfg_q;
  logic [CFG_BITS-1:0]      cfg_sum;

  assign widx     = cur_q[WI_HI:2];
  assign widx_inc = widx + 1'b1;
  assign nxt_lin  = cur_q + ADDR_W'(4);
  assign nxt_wrap = {cur_q[ADDR_W-1:WI_HI+1], (widx & ~mask_q) | (widx_inc & mask_q), 2'b00};
  assign cfg_sum  = cur_q[CFG_BITS-1:0] + CFG_BITS'(4);
  assign nxt_cfg  = {{(ADDR_W-CFG_BITS){1'b0}}, cfg_sum};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      mask_q   <= '0;
      active_q <= 1'b0;
      wrap_q   <= 1'b0;
      cfg_q    <= 1'b0;
    end else if (load) begin
      active_q <= dec.claim;
      wrap_q   <= dec.claim && dec.wrap;
      cfg_q    <= dec.claim && dec.is_cfg;
      mask_q   <= word_mask;
      if (!dec.claim)
        cur_q <= '0;
      else if (dec.is_cfg)
        cur_q <= {{(ADDR_W-CFG_BITS){1'b0}}, addr_in[CFG_BITS-1:2], 2'b00};
      else
        cur_q <= {addr_in[ADDR_W-1:2], 2'b00};
    end else if (adv && active_q) begin
      if (cfg_q)       cur_q <= nxt_cfg;
      else if (wrap_q) cur_q <= nxt_wrap;
      else             cur_q <= nxt_lin;
    end
  end

  assign cur_addr = cur_q;

  // R6: linear beat adds exactly one word
  assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && active_q && !wrap_q && !cfg_q) |=> cur_q == $past(cur_q) + ADDR_W'(4));

  // R7: wrap beat never touches bits above the largest line
  assert_wrap_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && wrap_q) |=> $stable(cur_q[ADDR_W-1:WI_HI+1]));

  // R8: configuration addresses stay inside the configuration space
  assert_cfg_space_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_q |-> cur_q[ADDR_W-1:CFG_BITS] == '0);

  // R3: nothing moves while idle
  assert_idle_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !load) |=> $stable(cur_q));

  // R10: a claimed memory address phase reloads from the bus
  assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (load && dec.claim && !dec.is_cfg) |=> cur_q[ADDR_W-1:2] == $past(addr_in[ADDR_W-1:2]));

  // R6: beat addresses are word aligned
  assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    cur_q[1:0] == 2'b00);

endmodule

// File: rtl/pci_tgt_front.sv
module pci_tgt_front
  import pci_tf_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int CFG_BITS        = 8,
  parameter int MAX_LINE_LOG2   = 4,
  parameter int MIN_LINE_LOG2   = 2,
  parameter int RESET_LINE_LOG2 = 3,
  parameter int CODE_W          = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] ad,
  input  logic              beat_adv,
  input  logic              line_wr,
  input  logic [CODE_W-1:0] line_code,
  output logic              claim,
  output logic [1:0]        kind,
  output logic              wrap_en,
  output logic [ADDR_W-1:0] beat_addr
);

  decode_t                  dec;
  logic [MAX_LINE_LOG2-1:0] word_mask;
  logic                     claim_q, wrap_q;
  xact_kind_e               kind_q;

  pci_tf_cmd_decode u_dec (
    .cmd   (cmd),
    .order (ad[1:0]),
    .dec   (dec)
  );

  pci_tf_line_size #(
    .MAX_LINE_LOG2   (MAX_LINE_LOG2),
    .MIN_LINE_LOG2   (MIN_LINE_LOG2),
    .RESET_LINE_LOG2 (RESET_LINE_LOG2),
    .CODE_W          (CODE_W)
  ) u_line (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (line_wr),
    .code      (line_code),
    .word_mask (word_mask)
  );

  pci_tf_beat_seq #(
    .ADDR_W        (ADDR_W),
    .CFG_BITS      (CFG_BITS),
    .MAX_LINE_LOG2 (MAX_LINE_LOG2)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (addr_valid),
    .dec       (dec),
    .addr_in   (ad),
    .word_mask (word_mask),
    .adv       (beat_adv),
    .cur_addr  (beat_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_q <= 1'b0;
      wrap_q  <= 1'b0;
      kind_q  <= KIND_MEM_RD;
    end else if (addr_valid) begin
      claim_q <= dec.claim;
      wrap_q  <= dec.claim && dec.wrap;
      kind_q  <= dec.claim ? dec.kind : KIND_MEM_RD;
    end
  end

  assign claim   = claim_q;
  assign wrap_en = wrap_q;
  assign kind    = kind_q;

  // R3: unclaimed outputs are quiet
  assert_unclaimed_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !claim |-> (!wrap_en && kind == 2'b00 && beat_addr == '0));

  // R3: dual address cycle is never claimed
  assert_no_dual_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && cmd == 4'b1101) |=> !claim);

  // R4: reserved memory orders are never claimed
  assert_reserved_order_R4: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && cmd != 4'b1010 && cmd != 4'b1011 && ad[0]) |=> !claim);

  // R5: wrap only on memory kinds
  assert_wrap_mem_only_R5: assert property (@(posedge clk) disable iff (rst)
    wrap_en |-> (claim && !kind[1]));

  // R8: configuration commands are always claimed
  assert_cfg_claimed_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && (cmd == 4'b1010 || cmd == 4'b1011)) |=> (claim && kind[1]));

endmodule

// File: tb/tb_pci_tgt_front.sv
module tb_pci_tgt_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_valid = 1'b0;
  logic [3:0]  cmd = '0;
  logic [31:0] ad = '0;
  logic        beat_adv = 1'b0;
  logic        line_wr = 1'b0;
  logic [1:0]  line_code = '0;
  logic        claim, wrap_en;
  logic [1:0]  kind;
  logic [31:0] beat_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pci_tgt_front dut (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .cmd(cmd), .ad(ad),
    .beat_adv(beat_adv), .line_wr(line_wr), .line_code(line_code),
    .claim(claim), .kind(kind), .wrap_en(wrap_en), .beat_addr(beat_addr)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [7:0]  beats;
    logic        claim;
    logic [1:0]  kind;
    logic        wrap;
    logic [31:0] first;
    logic [31:0] last;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'h6, 32'h1000_0000, 8'd3, 1'b1, 2'd0, 1'b0, 32'h1000_0000, 32'h1000_000C},
    '{4'h7, 32'h2000_0010, 8'd2, 1'b1, 2'd1, 1'b0, 32'h2000_0010, 32'h2000_0018},
    '{4'hC, 32'h3000_003A, 8'd3, 1'b1, 2'd0, 1'b1, 32'h3000_0038, 32'h3000_0024},
    '{4'hE, 32'h4000_001E, 8'd2, 1'b1, 2'd0, 1'b0, 32'h4000_001C, 32'h4000_0024},
    '{4'hF, 32'h5000_00F6, 8'd4, 1'b1, 2'd1, 1'b1, 32'h5000_00F4, 32'h5000_00E4},
    '{4'hA, 32'hABCD_EFF3, 8'd5, 1'b1, 2'd2, 1'b0, 32'h0000_00F0, 32'h0000_0004},
    '{4'hB, 32'h0000_0040, 8'd1, 1'b1, 2'd3, 1'b0, 32'h0000_0040, 32'h0000_0044},
    '{4'hD, 32'h1234_5678, 8'd2, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{4'h8, 32'h1111_1110, 8'd2, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{4'h9, 32'h2222_2220, 8'd1, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{4'h3, 32'h3333_3330, 8'd1, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{4'h6, 32'h4444_4441, 8'd1, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{4'hF, 32'h5555_5553, 8'd1, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{4'h7, 32'hFFFF_FFF8, 8'd3, 1'b1, 2'd1, 1'b0, 32'hFFFF_FFF8, 32'h0000_0004},
    '{4'h7, 32'h6000_003E, 8'd1, 1'b1, 2'd1, 1'b0, 32'h6000_003C, 32'h6000_0040}
  };

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic addr_phase(input logic [3:0] c, input logic [31:0] a, input logic also_beat);
    addr_valid = 1'b1; cmd = c; ad = a; beat_adv = also_beat;
    @(negedge clk);
    addr_valid = 1'b0; beat_adv = 1'b0;
  endtask

  task automatic beats(input int n);
    for (int k = 0; k < n; k++) begin
      beat_adv = 1'b1;
      @(negedge clk);
      beat_adv = 1'b0;
    end
  endtask

  task automatic set_line(input logic [1:0] code);
    line_wr = 1'b1; line_code = code;
    @(negedge clk);
    line_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", "claim", 32'(claim), 32'd0);
    check("R1", "kind", 32'(kind), 32'd0);
    check("R1", "wrap_en", 32'(wrap_en), 32'd0);
    check("R1", "beat_addr", beat_addr, 32'd0);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 (line size 8 words after reset)
    for (int i = 0; i < NV; i++) begin
      addr_phase(VECS[i].cmd, VECS[i].addr, 1'b0);
      check("R2", "claim", 32'(claim), 32'(VECS[i].claim));
      check("R2", "kind", 32'(kind), 32'(VECS[i].kind));
      check("R5", "wrap_en", 32'(wrap_en), 32'(VECS[i].wrap));
      check("R6", "first beat", beat_addr, VECS[i].first);
      beats(int'(VECS[i].beats));
      check("R7", "last beat", beat_addr, VECS[i].last);
    end

    // R9: 4-word line, word 2 of line 0x10 wraps 3 -> 0 -> 1
    set_line(2'd0);
    addr_phase(4'hC, 32'h7000_001A, 1'b0);
    beats(3);
    check("R9", "4-word wrap", beat_addr, 32'h7000_0014);

    // R9: 16-word line, 15 beats from word 1 lands on word 0
    set_line(2'd2);
    addr_phase(4'hF, 32'h8000_0006, 1'b0);
    beats(15);
    check("R9", "16-word wrap", beat_addr, 32'h8000_0000);

    // R9: code 3 ignored, size stays 16 words
    set_line(2'd3);
    addr_phase(4'hF, 32'h8000_003E, 1'b0);
    beats(1);
    check("R9", "code 3 ignored", beat_addr, 32'h8000_0000);

    // R9: size held from the address phase despite a mid-burst write
    addr_phase(4'hC, 32'h9000_003E, 1'b0);
    set_line(2'd0);
    beats(1);
    check("R9", "size sampled at phase", beat_addr, 32'h9000_0000);

    // R10: simultaneous address phase and beat, reload wins
    addr_phase(4'h6, 32'hA000_0100, 1'b0);
    beats(2);
    addr_phase(4'h6, 32'hA000_0000, 1'b1);
    check("R10", "reload over beat", beat_addr, 32'hA000_0000);

    // R10: new unclaimed phase drops the burst
    beats(1);
    addr_phase(4'hD, 32'hB000_0000, 1'b0);
    check("R10", "dropped claim", 32'(claim), 32'd0);
    beats(2);
    check("R3", "idle beat_addr", beat_addr, 32'd0);

    // R1: reset in mid-burst clears the outputs
    addr_phase(4'hF, 32'hC000_0002, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "claim after reset", 32'(claim), 32'd0);
    check("R1", "beat_addr after reset", beat_addr, 32'd0);

    // R1: line size back to 8 words after reset
    addr_phase(4'hC, 32'hD000_003E, 1'b0);
    beats(1);
    check("R1", "8-word default", beat_addr, 32'hD000_0020);

    finish_run();
  end

endmodule